// File: doc/BRIEF.md
# Prescaled Timer With PWM Modes

This block is an 8-bit up-counter preceded by a prescaler whose division ratio is a power of two up to 2^16. Together they span up to 2^24 source events for each full counter cycle. The prescaler is fed either by the master clock or by an external count clock, which is synchronized into the master clock domain. Counting is controlled in one of four ways. In free-running mode and PWM mode a run input gates the counter. In level mode the counter runs only while an external start pin is high. In edge mode the first rising edge of the start pin opens a measurement and the next rising edge closes it, so the frozen count is the pin period in prescaled ticks.

In PWM mode the output is high from each counter restart and goes low once the count reaches the active compare value. It stays low until the counter wraps. The active compare value is a shadow copy of the reload input. It is refreshed only when the counter restarts, so software can change the reload value at any time without producing a glitch. An interrupt strobe marks either each counter wrap or the close of an edge measurement. A two-bit status word shows whether the timer is counting and whether it is held in reset.

Top module: `prescaled_pwm_timer`

## Requirements
- R1: While rst_ni is low, count_o is 0, irq_o is 0 and pwm_o is 0. The edge-measurement state returns to waiting.
- R2: With code n (0..16) in psc_code_i and the master clock as source (clk_sel_i=0), count_o advances by one on every 2^n-th master cycle in which the timer is counting. It wraps from 255 to 0.
- R3: A psc_code_i value above 16 divides exactly as code 16 does.
- R4: With clk_sel_i=1, each source event is a rising edge of ext_clk_i seen after a two-flop synchronizer. The master clock then has no direct effect on counting.
- R5: mode_i encodes 0 free-running, 1 PWM, 2 level, 3 edge. In PWM mode pwm_o is 1 exactly while count_o is below the active compare value. In every other mode pwm_o is 0.
- R6: The active compare value takes reload_i only when the counter wraps to 0 or while hold_i is high. A change of reload_i at any other time has no effect on pwm_o before the next wrap.
- R7: In level mode the timer counts only while the synchronized start_pin_i is high, regardless of run_i. A high window of H master cycles at code 0 adds H to the count.
- R8: In edge mode counting starts after the first synchronized rising edge of start_pin_i and stops after the next one. The count then stays frozen, and later edges are ignored until hold_i is raised.
- R9: irq_o is a single-cycle pulse. When irq_sel_i=0 it follows each counter wrap. When irq_sel_i=1 it follows the closing edge of an edge-mode measurement.
- R10: status_o[0] is 1 while the timer is counting. status_o[1] is 1 while hold_i is high.
- R11: While hold_i is high, the counter and the prescaler are cleared and no counting takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External count clock, at most half the master rate |
| start_pin_i | input | 1 | External start pin for level and edge modes |
| clk_sel_i | input | 1 | Prescaler source: 0 master clock, 1 external clock |
| hold_i | input | 1 | Holds the timer in reset |
| run_i | input | 1 | Run enable in free-running and PWM modes |
| irq_sel_i | input | 1 | Interrupt cause: 0 wrap, 1 end of measurement |
| mode_i | input | 2 | Timer mode (0 free, 1 PWM, 2 level, 3 edge) |
| psc_code_i | input | 5 | Prescaler exponent code |
| reload_i | input | 8 | Reload value for the compare shadow |
| pwm_o | output | 1 | PWM output |
| count_o | output | 8 | Current counter value |
| status_o | output | 2 | {held in reset, counting} |
| irq_o | output | 1 | Interrupt strobe |

## Verification
The hardest case to reach from the ports is the largest prescaler setting. A clamped code such as 17 needs 65,536 counting cycles per tick, so the bench spends one long uninterrupted run on it and checks that exactly two ticks have occurred. The reload shadow is also hard to observe. The bench changes reload_i in the middle of a PWM period and samples pwm_o at a count that lies between the old and new compare values, once before the wrap and once after it. The edge-mode measurement is driven with a known pin period, and its frozen result is checked after a further edge that must be ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_PWM   = 2'd1,
    MODE_LEVEL = 2'd2,
    MODE_EDGE  = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    MEAS_WAIT = 2'd0,
    MEAS_RUN  = 2'd1,
    MEAS_DONE = 2'd2
  } meas_st_e;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= d_i;
      prev_q    <= sync_q[STAGES-1];
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W  = 16,
  parameter int CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              src_en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int EXP_W = $clog2(PRE_W + 1);

  logic [EXP_W-1:0] exp_s;
  logic [PRE_W-1:0] mask_s;
  logic [PRE_W-1:0] pre_q;

  // codes beyond the prescaler width clamp to the widest ratio
  always_comb begin
    if (int'(code_i) > PRE_W) exp_s = EXP_W'(PRE_W);
    else                      exp_s = EXP_W'(code_i);
  end

  for (genvar b = 0; b < PRE_W; b++) begin : g_mask
    assign mask_s[b] = (int'(exp_s) > b);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_q <= '0;
    else if (clr_i)    pre_q <= '0;
    else if (src_en_i) pre_q <= pre_q + 1'b1;
  end

  assign tick_o = src_en_i & ((pre_q & mask_s) == mask_s);

  assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pre_q == '0));
endmodule

// File: rtl/tmr_gate.sv
module tmr_gate
  import tmr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hold_i,
  input  tmr_mode_e mode_i,
  input  logic      run_i,
  input  logic      pin_lvl_i,
  input  logic      pin_rise_i,
  output logic      run_o,
  output logic      meas_done_o
);
  meas_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (hold_i || mode_i != MODE_EDGE) begin
      st_d = MEAS_WAIT;
    end else begin
      unique case (st_q)
        MEAS_WAIT: if (pin_rise_i) st_d = MEAS_RUN;
        MEAS_RUN:  if (pin_rise_i) st_d = MEAS_DONE;
        default:   st_d = MEAS_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= MEAS_WAIT;
    else         st_q <= st_d;
  end

  always_comb begin
    run_o = 1'b0;
    if (!hold_i) begin
      unique case (mode_i)
        MODE_FREE, MODE_PWM: run_o = run_i;
        MODE_LEVEL:          run_o = pin_lvl_i;
        default:             run_o = (st_q == MEAS_RUN);
      endcase
    end
  end

  assign meas_done_o = !hold_i && mode_i == MODE_EDGE && st_q == MEAS_RUN && pin_rise_i;

  assert_meas_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MEAS_DONE && !hold_i && mode_i == MODE_EDGE) |=> (st_q == MEAS_DONE));

  assert_meas_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MEAS_DONE && $past(st_q) != MEAS_DONE) |-> ($past(st_q) == MEAS_RUN));
endmodule

// File: rtl/prescaled_pwm_timer.sv
module prescaled_pwm_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 16,
  parameter int CODE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic              start_pin_i,
  input  logic              clk_sel_i,
  input  logic              hold_i,
  input  logic              run_i,
  input  logic              irq_sel_i,
  input  logic [1:0]        mode_i,
  input  logic [CODE_W-1:0] psc_code_i,
  input  logic [CNT_W-1:0]  reload_i,
  output logic              pwm_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [1:0]        status_o,
  output logic              irq_o
);
  tmr_mode_e mode_s;
  logic ext_lvl, ext_rise, pin_lvl, pin_rise;
  logic run_s, meas_done_s, src_en_s, pre_tick_s, tick_s, wrap_s;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic irq_q;

  assign mode_s = tmr_mode_e'(mode_i);

  tmr_sync #(.STAGES(SYNC_STAGES)) i_ext_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_clk_i), .lvl_o(ext_lvl), .rise_o(ext_rise)
  );

  tmr_sync #(.STAGES(SYNC_STAGES)) i_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(start_pin_i), .lvl_o(pin_lvl), .rise_o(pin_rise)
  );

  tmr_gate i_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .mode_i(mode_s), .run_i(run_i),
    .pin_lvl_i(pin_lvl), .pin_rise_i(pin_rise), .run_o(run_s), .meas_done_o(meas_done_s)
  );

  assign src_en_s = clk_sel_i ? ext_rise : 1'b1;

  tmr_prescaler #(.PRE_W(PRE_W), .CODE_W(CODE_W)) i_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!run_s), .src_en_i(src_en_s),
    .code_i(psc_code_i), .tick_o(pre_tick_s)
  );

  assign tick_s = run_s & pre_tick_s;
  assign wrap_s = tick_s & (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
      irq_q <= 1'b0;
    end else if (hold_i) begin
      cnt_q <= '0;
      cmp_q <= reload_i;
      irq_q <= 1'b0;
    end else begin
      if (tick_s) cnt_q <= cnt_q + 1'b1;
      if (wrap_s) cmp_q <= reload_i;
      irq_q <= irq_sel_i ? meas_done_s : wrap_s;
    end
  end

  assign count_o  = cnt_q;
  assign pwm_o    = (mode_s == MODE_PWM) && (cnt_q < cmp_q);
  assign status_o = {hold_i, run_s};
  assign irq_o    = irq_q;

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == CNT_W'($past(cnt_q) + 1'b1)) || (cnt_q == '0)));

  assert_hold_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (count_o == '0));

  assert_irq_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_pwm_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_s == MODE_PWM && $past(mode_s) == MODE_PWM && $rose(pwm_o)) |-> (count_o == '0));

  assert_status_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1] |-> !status_o[0]);
endmodule

// File: tb/test_prescaled_pwm_timer.sv
module test_prescaled_pwm_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_clk = 1'b0, pin = 1'b0, clk_sel = 1'b0, hold = 1'b1, run = 1'b0, irq_sel = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [4:0] code = 5'd0;
  logic [7:0] reload = 8'd0;
  logic pwm, irq;
  logic [7:0] count;
  logic [1:0] status;

  int n_checks = 0, n_fail = 0;
  string cur_req = "R2";
  int ext_half = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_pwm_timer i_prescaled_pwm_timer (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk), .start_pin_i(pin), .clk_sel_i(clk_sel),
    .hold_i(hold), .run_i(run), .irq_sel_i(irq_sel), .mode_i(mode), .psc_code_i(code),
    .reload_i(reload), .pwm_o(pwm), .count_o(count), .status_o(status), .irq_o(irq)
  );

  // behavioural reference state
  bit m_p1, m_p2, m_p3, m_e1, m_e2, m_e3, m_irq;
  int m_pre, m_cnt, m_cmp, m_est;

  function automatic bit m_running();
    if (hold) return 0;
    case (mode)
      2'd0, 2'd1: return run;
      2'd2:       return m_p2;
      default:    return m_est == 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_p1, m_p2, m_p3, m_e1, m_e2, m_e3, m_irq} = '0;
      m_pre = 0; m_cnt = 0; m_cmp = 0; m_est = 0;
    end else begin
      automatic bit rn = m_running();
      automatic bit prise = m_p2 && !m_p3;
      automatic bit src = clk_sel ? (m_e2 && !m_e3) : 1'b1;
      automatic int e = (code > 16) ? 16 : int'(code);
      automatic int div = 1 << e;
      automatic bit tk = rn && src && ((m_pre % div) == div - 1);
      automatic bit ovf = tk && m_cnt == 255;
      automatic bit done = 0;
      if (hold) begin
        m_cnt = 0; m_pre = 0; m_cmp = reload; m_est = 0; m_irq = 0;
      end else begin
        if (!rn) m_pre = 0;
        else if (src) m_pre = (m_pre + 1) % 65536;
        if (tk) m_cnt = (m_cnt + 1) % 256;
        if (ovf) m_cmp = reload;
        if (mode != 2'd3) m_est = 0;
        else if (m_est == 0 && prise) m_est = 1;
        else if (m_est == 1 && prise) begin m_est = 2; done = 1; end
        m_irq = irq_sel ? done : ovf;
      end
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = pin;
      m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_clk;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle compare against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit ep = (mode == 2'd1) && (m_cnt < m_cmp);
      check(cur_req, int'(count), m_cnt, "count");
      check("R5", int'(pwm), int'(ep), "pwm");
      check("R9", int'(irq), int'(m_irq), "irq");
      check("R10", int'(status), int'({hold, m_running()}), "status");
    end
  end

  // external count clock, toggled away from the master edge
  always @(posedge clk) begin
    automatic int ph;
    #1;
    if (ext_half > 0) begin
      ph = int'($time / CLK_PERIOD) % (2 * ext_half);
      ext_clk = (ph < ext_half);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic restart();
    hold = 1'b1; step(2); hold = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    step(3);
    // R1: reset state
    check("R1", int'(count), 0, "count in reset");
    check("R1", int'(irq), 0, "irq in reset");
    check("R1", int'(pwm), 0, "pwm in reset");
    rst_n = 1'b1;
    step(2);
    // R11 / R10: hold keeps counter cleared
    cur_req = "R11"; run = 1'b1; step(20);
    check("R11", int'(count), 0, "count under hold");
    check("R10", int'(status[1]), 1, "hold status");

    // R2: code 0 free run, wrap and irq
    cur_req = "R2"; code = 5'd0; hold = 1'b0; step(300);
    code = 5'd3; restart(); step(164);
    check("R2", int'(count), 20, "count after 164 cycles /8");
    step(400);
    run = 1'b0; step(30);
    check("R10", int'(status[0]), 0, "stopped status");
    run = 1'b1;

    // R5 / R6: PWM with shadow reload
    cur_req = "R6"; mode = 2'd1; code = 5'd0; reload = 8'd100; restart(); step(20);
    reload = 8'd40; step(50);
    check("R6", int'(pwm), 1, "pwm before wrap with old compare");
    step(246);
    check("R6", int'(pwm), 0, "pwm after wrap with new compare");
    cur_req = "R5"; reload = 8'd0; restart(); step(300);
    reload = 8'd255; restart(); step(300);
    mode = 2'd0; step(20);
    check("R5", int'(pwm), 0, "pwm outside PWM mode");

    // R4: external clock source
    cur_req = "R4"; clk_sel = 1'b1; ext_half = 4; code = 5'd1; step(10); restart(); step(900);
    ext_half = 3; code = 5'd0; restart(); step(600);
    clk_sel = 1'b0; ext_half = 0;

    // R7: level mode, run ignored
    cur_req = "R7"; mode = 2'd2; run = 1'b0; pin = 1'b0; restart(); step(10);
    pin = 1'b1; step(40); pin = 1'b0; step(15);
    check("R7", int'(count), 40, "level window count");
    pin = 1'b1; step(23); pin = 1'b0; step(9); pin = 1'b1; step(5); pin = 1'b0; step(15);

    // R8 / R9: edge measurement with interrupt on completion
    cur_req = "R8"; mode = 2'd3; irq_sel = 1'b1; restart(); step(5);
    pin = 1'b1; step(10); pin = 1'b0; step(27);
    pin = 1'b1; step(10); pin = 1'b0; step(20);
    check("R8", int'(count), 37, "measured period");
    pin = 1'b1; step(10); pin = 1'b0; step(20);
    check("R8", int'(count), 37, "later edge ignored");
    irq_sel = 1'b0;

    // R3: clamped code behaves as 16
    cur_req = "R3"; mode = 2'd0; run = 1'b1; code = 5'd17; restart(); step(131200);
    check("R3", int'(count), 2, "ticks at clamped code");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule